// File: doc/BRIEF.md
# Exception Mask Special-Register File

This block keeps the interrupt and exception masking state of a small microcontroller core. The core reads and writes it with move-from and move-to special-register operations. A combinational read port and a clocked write port are each addressed by a special-register number. The block holds a one-bit global interrupt disable, a one-bit fault disable, an 8-bit priority floor and a 2-bit mode control word. It also keeps a pair of banked stack pointers, reached through two alias numbers. The current mask values go straight to the interrupt controller, and the active stack pointer goes to the core.

Writes to two numbers target the priority floor. One stores the value as it comes. The other only raises the masking level: it takes a value only when the value is nonzero and either the floor is zero or the value is numerically smaller. When a write to the mode control word flips bit 1, the active and banked stack pointers trade places in the same cycle.

Top module: `emr_regfile`

## Requirements
- R1: After reset the interrupt disable, fault disable, priority floor, mode control and both stack pointers are zero, and reads of numbers 8, 9, 16, 17, 18, 19 and 20 return zero.
- R2: Number 16 is the interrupt disable bit. A write loads it from data bit 0. A read returns it in bit 0 with the upper bits zero. Output `irq_disable_o` shows it.
- R3: Number 17 is the priority floor. A write stores data bits 7:0 with no condition. Reads of 17 and of 18 both return the floor, zero-extended. Output `prio_floor_o` shows it.
- R4: A write to number 18 masks the data to bits 7:0. It updates the floor only when that value is nonzero and the floor is zero or greater than the value. Any other write to 18 leaves the floor unchanged.
- R5: Number 19 is the fault disable bit. A write loads it from data bit 0. A read returns it in bit 0. Output `fault_disable_o` shows it.
- R6: Number 20 is the mode control word. A write keeps data bits 1:0. A read returns them zero-extended. Output `ctrl_o` shows them.
- R7: Number 8 names the main stack pointer and number 9 the process stack pointer. Control bit 1 = 0 makes the main one active, and 1 makes the process one active. `sp_active_o` shows the active one. A write or read of either number reaches that stack pointer whichever is active.
- R8: A control write that changes bit 1 swaps which stack pointer is active in the same cycle, and both stored values are kept. A control write that leaves bit 1 unchanged does not change `sp_active_o`.
- R9: A read of any other number returns zero. A write to any other number changes no state.
- R10: Reads are combinational from the current state. Writes take effect at the next rising clock edge, so a read in the same cycle as a write to the same number returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_num | input | 8 | Special-register number to read |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_num | input | 8 | Special-register number to write |
| wr_data | input | 32 | Write data |
| irq_disable_o | output | 1 | Global interrupt disable to the interrupt controller |
| fault_disable_o | output | 1 | Fault disable to the interrupt controller |
| prio_floor_o | output | 8 | Priority floor to the interrupt controller |
| ctrl_o | output | 2 | Mode control word |
| sp_active_o | output | 32 | Active stack pointer |

## Verification
The bench walks the raise-only write through every branch. It covers a zero floor, a smaller value, an equal value, a larger value, and data whose low byte is zero but whose upper bits are set. A design that compared before masking, or used "less or equal", would move the floor when it must not. It flips control bit 1 both ways, and also rewrites the control word with bit 1 unchanged, then reads both stack pointer aliases. A design that swapped on every control write, or lost a value in the swap, shows the wrong active pointer or a corrupted alias. It also reads a register in the same cycle it is written, which catches a read path taken from the next-state value, and writes unsupported numbers, which catches decode aliasing onto live registers.

// File: rtl/emr_pkg.sv
package emr_pkg;

    localparam int unsigned NUM_W = 8;

    // Register numbers decoded by the core's special-register move path
    localparam logic [NUM_W-1:0] NUM_SP_MAIN   = 8'd8;
    localparam logic [NUM_W-1:0] NUM_SP_PROC   = 8'd9;
    localparam logic [NUM_W-1:0] NUM_IRQ_OFF   = 8'd16;
    localparam logic [NUM_W-1:0] NUM_FLOOR     = 8'd17;
    localparam logic [NUM_W-1:0] NUM_FLOOR_MAX = 8'd18;
    localparam logic [NUM_W-1:0] NUM_FAULT_OFF = 8'd19;
    localparam logic [NUM_W-1:0] NUM_CTRL      = 8'd20;

    // Bit of the control word that selects the process stack pointer
    localparam int unsigned CTRL_SP_BIT = 1;

    typedef struct packed {
        logic sp_main;
        logic sp_proc;
        logic irq_off;
        logic floor;
        logic floor_max;
        logic fault_off;
        logic ctrl;
    } sel_t;

endpackage

// File: rtl/emr_decode.sv
module emr_decode
    import emr_pkg::*;
(
    input  logic [NUM_W-1:0] num,
    output sel_t             sel,
    output logic             hit
);

    always_comb begin
        sel           = '0;
        sel.sp_main   = (num == NUM_SP_MAIN);
        sel.sp_proc   = (num == NUM_SP_PROC);
        sel.irq_off   = (num == NUM_IRQ_OFF);
        sel.floor     = (num == NUM_FLOOR);
        sel.floor_max = (num == NUM_FLOOR_MAX);
        sel.fault_off = (num == NUM_FAULT_OFF);
        sel.ctrl      = (num == NUM_CTRL);
        hit           = |sel;
    end

endmodule

// File: rtl/emr_prio_rule.sv
module emr_prio_rule #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_plain,
    input  logic              wr_raise,
    output logic [PRIO_W-1:0] nxt
);

    logic [PRIO_W-1:0] val;
    logic              val_nz;
    logic              cur_zero;
    logic              tighter;

    always_comb begin
        val      = wdata[PRIO_W-1:0];
        val_nz   = |val;
        cur_zero = ~|cur;
        tighter  = (val < cur);
        nxt      = cur;
        if (wr_plain) begin
            nxt = val;
        end else if (wr_raise && val_nz && (cur_zero || tighter)) begin
            nxt = val;
        end
    end

endmodule

// File: rtl/emr_sp_bank.sv
module emr_sp_bank #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] act_q,
    input  logic [DATA_W-1:0] oth_q,
    input  logic              proc_sel_q,
    input  logic              ctrl_wr,
    input  logic              proc_sel_new,
    input  logic              wr_main,
    input  logic              wr_proc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] act_d,
    output logic [DATA_W-1:0] oth_d,
    output logic [DATA_W-1:0] main_val,
    output logic [DATA_W-1:0] proc_val
);

    logic swap;

    always_comb begin
        main_val = proc_sel_q ? oth_q : act_q;
        proc_val = proc_sel_q ? act_q : oth_q;
        swap     = ctrl_wr && (proc_sel_new != proc_sel_q);
        act_d    = act_q;
        oth_d    = oth_q;
        if (swap) begin
            act_d = oth_q;
            oth_d = act_q;
        end else if (wr_main) begin
            if (proc_sel_q) oth_d = wdata;
            else            act_d = wdata;
        end else if (wr_proc) begin
            if (proc_sel_q) act_d = wdata;
            else            oth_d = wdata;
        end
    end

endmodule

// File: rtl/emr_regfile.sv
module emr_regfile
    import emr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rd_num,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [7:0]        wr_num,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_disable_o,
    output logic              fault_disable_o,
    output logic [PRIO_W-1:0] prio_floor_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] sp_active_o
);

    localparam int unsigned PRIO_PAD = DATA_W - PRIO_W;
    localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;

    typedef struct packed {
        logic              irq_off;
        logic              fault_off;
        logic [PRIO_W-1:0] floor;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] sp_act;
        logic [DATA_W-1:0] sp_oth;
    } state_t;

    state_t st_q, st_d;

    sel_t rsel, wsel;
    logic rhit, whit;

    emr_decode u_rd_dec (.num(rd_num), .sel(rsel), .hit(rhit));
    emr_decode u_wr_dec (.num(wr_num), .sel(wsel), .hit(whit));

    logic [PRIO_W-1:0] floor_nxt;

    emr_prio_rule #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_prio (
        .cur      (st_q.floor),
        .wdata    (wr_data),
        .wr_plain (wr_en && wsel.floor),
        .wr_raise (wr_en && wsel.floor_max),
        .nxt      (floor_nxt)
    );

    logic [DATA_W-1:0] sp_act_nxt, sp_oth_nxt, sp_main_val, sp_proc_val;

    emr_sp_bank #(.DATA_W(DATA_W)) u_sp (
        .act_q        (st_q.sp_act),
        .oth_q        (st_q.sp_oth),
        .proc_sel_q   (st_q.ctrl[CTRL_SP_BIT]),
        .ctrl_wr      (wr_en && wsel.ctrl),
        .proc_sel_new (wr_data[CTRL_SP_BIT]),
        .wr_main      (wr_en && wsel.sp_main),
        .wr_proc      (wr_en && wsel.sp_proc),
        .wdata        (wr_data),
        .act_d        (sp_act_nxt),
        .oth_d        (sp_oth_nxt),
        .main_val     (sp_main_val),
        .proc_val     (sp_proc_val)
    );

    // Next-state process
    always_comb begin
        st_d        = st_q;
        st_d.floor  = floor_nxt;
        st_d.sp_act = sp_act_nxt;
        st_d.sp_oth = sp_oth_nxt;
        if (wr_en) begin
            if (wsel.irq_off)   st_d.irq_off   = wr_data[0];
            if (wsel.fault_off) st_d.fault_off = wr_data[0];
            if (wsel.ctrl)      st_d.ctrl      = wr_data[CTRL_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read port, combinational from the registered state
    always_comb begin
        rd_data = '0;
        if (rhit) begin
            unique case (1'b1)
                rsel.sp_main:                rd_data = sp_main_val;
                rsel.sp_proc:                rd_data = sp_proc_val;
                rsel.irq_off:                rd_data = {{(DATA_W-1){1'b0}}, st_q.irq_off};
                rsel.floor, rsel.floor_max:  rd_data = {{PRIO_PAD{1'b0}}, st_q.floor};
                rsel.fault_off:              rd_data = {{(DATA_W-1){1'b0}}, st_q.fault_off};
                rsel.ctrl:                   rd_data = {{CTRL_PAD{1'b0}}, st_q.ctrl};
                default:                     rd_data = '0;
            endcase
        end
    end

    assign irq_disable_o   = st_q.irq_off;
    assign fault_disable_o = st_q.fault_off;
    assign prio_floor_o    = st_q.floor;
    assign ctrl_o          = st_q.ctrl;
    assign sp_active_o     = st_q.sp_act;

endmodule

// File: rtl/emr_regfile_chk.sv
module emr_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned CTRL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rd_num,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [7:0]        wr_num,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_disable_o,
    input logic              fault_disable_o,
    input logic [PRIO_W-1:0] prio_floor_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [DATA_W-1:0] sp_active_o
);

    logic [PRIO_W-1:0] wv;
    logic              raise_ok;
    logic              known_wr;
    logic              sp_touch;

    always_comb begin
        wv       = wr_data[PRIO_W-1:0];
        raise_ok = (wv != '0) && ((prio_floor_o == '0) || (wv < prio_floor_o));
        known_wr = (wr_num == 8'd8) || (wr_num == 8'd9) ||
                   ((wr_num >= 8'd16) && (wr_num <= 8'd20));
        sp_touch = wr_en && ((wr_num == 8'd8) || (wr_num == 8'd9) || (wr_num == 8'd20));
    end

    // R2
    irq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd16 |=> irq_disable_o == $past(wr_data[0]));

    // R3
    floor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd17 |=> prio_floor_o == $past(wr_data[PRIO_W-1:0]));

    // R3
    floor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_num == 8'd17 || rd_num == 8'd18) |-> rd_data == DATA_W'(prio_floor_o));

    // R4
    raise_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd18 && raise_ok |=> prio_floor_o == $past(wr_data[PRIO_W-1:0]));

    // R4
    raise_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd18 && !raise_ok |=> $stable(prio_floor_o));

    // R5
    fault_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd19 |=> fault_disable_o == $past(wr_data[0]));

    // R6
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_num == 8'd20 |=> ctrl_o == $past(wr_data[CTRL_W-1:0]));

    // R8
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_touch |=> $stable(sp_active_o));

    // R9
    unknown_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !known_wr |=> $stable(irq_disable_o) && $stable(fault_disable_o) &&
            $stable(prio_floor_o) && $stable(ctrl_o) && $stable(sp_active_o));

endmodule

bind emr_regfile emr_regfile_chk #(
    .DATA_W(DATA_W), .PRIO_W(PRIO_W), .CTRL_W(CTRL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_data(rd_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .irq_disable_o(irq_disable_o), .fault_disable_o(fault_disable_o),
    .prio_floor_o(prio_floor_o), .ctrl_o(ctrl_o), .sp_active_o(sp_active_o)
);

// File: tb/emr_regfile_tb.sv
module emr_regfile_tb;

    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_num = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_num = '0;
    logic [31:0] wr_data = '0;
    logic        irq_disable_o, fault_disable_o;
    logic [7:0]  prio_floor_o;
    logic [1:0]  ctrl_o;
    logic [31:0] sp_active_o;

    always #2 clk = ~clk;

    emr_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_data(rd_data),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .irq_disable_o(irq_disable_o), .fault_disable_o(fault_disable_o),
        .prio_floor_o(prio_floor_o), .ctrl_o(ctrl_o), .sp_active_o(sp_active_o)
    );

    // Observation points: 0 rd_data, 1 irq, 2 fault, 3 floor, 4 ctrl, 5 active sp
    typedef struct {
        int          what;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Monitor: samples one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.what)
                    0: act = rd_data;
                    1: act = {31'd0, irq_disable_o};
                    2: act = {31'd0, fault_disable_o};
                    3: act = {24'd0, prio_floor_o};
                    4: act = {30'd0, ctrl_o};
                    default: act = sp_active_o;
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: item %0d actual %h expected %h", it.tag, it.what, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(input int what, input logic [31:0] exp, input string tag);
        item_t it;
        it.what = what; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Drive rd_num at a falling edge, queue the expectation, hold one cycle
    task automatic chk_rd(input logic [7:0] n, input logic [31:0] exp, input string tag);
        rd_num = n;
        expect_out(0, exp, tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] n, input logic [31:0] d);
        wr_en = 1'b1; wr_num = n; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_num = 8'd0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_out(1, 0, "R1"); expect_out(2, 0, "R1"); expect_out(3, 0, "R1");
        expect_out(4, 0, "R1"); expect_out(5, 0, "R1");
        chk_rd(8'd16, 0, "R1"); chk_rd(8'd17, 0, "R1"); chk_rd(8'd18, 0, "R1");
        chk_rd(8'd19, 0, "R1"); chk_rd(8'd20, 0, "R1");
        chk_rd(8'd8, 0, "R1");  chk_rd(8'd9, 0, "R1");

        // R2 interrupt disable
        wr(8'd16, 32'hFFFF_FFFE); expect_out(1, 0, "R2");
        wr(8'd16, 32'h0000_0003); expect_out(1, 1, "R2");
        chk_rd(8'd16, 32'h1, "R2");
        wr(8'd16, 32'h0000_0002); expect_out(1, 0, "R2");
        chk_rd(8'd16, 32'h0, "R2");

        // R3 plain floor write
        wr(8'd17, 32'h1234_56A5); expect_out(3, 32'hA5, "R3");
        chk_rd(8'd17, 32'hA5, "R3");
        chk_rd(8'd18, 32'hA5, "R3");

        // R4 raise-only rule
        wr(8'd17, 32'h0);
        wr(8'd18, 32'h0);         expect_out(3, 32'h00, "R4 zero value");
        wr(8'd18, 32'h0000_0140); expect_out(3, 32'h40, "R4 from zero floor");
        wr(8'd18, 32'h80);        expect_out(3, 32'h40, "R4 larger ignored");
        wr(8'd18, 32'h40);        expect_out(3, 32'h40, "R4 equal ignored");
        wr(8'd18, 32'h20);        expect_out(3, 32'h20, "R4 smaller taken");
        wr(8'd18, 32'h0000_0100); expect_out(3, 32'h20, "R4 masked zero ignored");
        chk_rd(8'd18, 32'h20, "R4");
        wr(8'd17, 32'hF0);        expect_out(3, 32'hF0, "R3 lower priority");

        // R5 fault disable
        wr(8'd19, 32'h0000_0005); expect_out(2, 1, "R5");
        chk_rd(8'd19, 32'h1, "R5");
        wr(8'd19, 32'hFFFF_FFFE); expect_out(2, 0, "R5");

        // R6 control word
        wr(8'd20, 32'hFFFF_FFFD); expect_out(4, 32'h1, "R6");
        chk_rd(8'd20, 32'h1, "R6");
        wr(8'd20, 32'h0);

        // R7 stack pointer aliases
        wr(8'd8, 32'h0000_1000);  expect_out(5, 32'h1000, "R7 main active");
        wr(8'd9, 32'h0000_2000);  expect_out(5, 32'h1000, "R7 proc banked");
        chk_rd(8'd8, 32'h1000, "R7");
        chk_rd(8'd9, 32'h2000, "R7");

        // R8 swap on bit 1 change
        wr(8'd20, 32'h2);         expect_out(5, 32'h2000, "R8 swap to proc");
        chk_rd(8'd8, 32'h1000, "R8");
        chk_rd(8'd9, 32'h2000, "R8");
        wr(8'd20, 32'h3);         expect_out(5, 32'h2000, "R8 no swap");
        wr(8'd9, 32'h0000_3000);  expect_out(5, 32'h3000, "R7 write active proc");
        chk_rd(8'd8, 32'h1000, "R7");
        wr(8'd20, 32'h0);         expect_out(5, 32'h1000, "R8 swap to main");
        chk_rd(8'd9, 32'h3000, "R8");

        // R9 unsupported numbers
        chk_rd(8'd5, 0, "R9"); chk_rd(8'd21, 0, "R9"); chk_rd(8'd255, 0, "R9");
        wr(8'd16, 32'h1);
        wr(8'd21, 32'hFFFF_FFFF);
        wr(8'd15, 32'hFFFF_FFFF);
        wr(8'd0,  32'hFFFF_FFFF);
        expect_out(1, 1, "R9"); expect_out(2, 0, "R9"); expect_out(3, 32'hF0, "R9");
        expect_out(4, 0, "R9"); expect_out(5, 32'h1000, "R9");
        chk_rd(8'd9, 32'h3000, "R9");

        // R10 same-cycle read returns old value
        rd_num = 8'd17;
        expect_out(0, 32'hF0, "R10 old value");
        wr(8'd17, 32'h55);
        chk_rd(8'd17, 32'h55, "R10 new value");
        rd_num = 8'd20;
        expect_out(0, 32'h0, "R10 old ctrl");
        wr(8'd20, 32'h1);
        chk_rd(8'd20, 32'h1, "R10 new ctrl");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule